// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Read Mode

This block is a first-in first-out buffer whose write side and read side each run on their own clock. Words enter on the write clock while the active-low write enable is asserted. They leave through a registered output on the read clock. Each side has one active-low status flag, and two programmable threshold flags warn when the buffer is nearly drained or nearly filled. The two thresholds are offsets held in registers, which are written through a small configuration port on the write clock.

A mode input is captured when master reset is released. In standard mode the read-side flag reports empty and the write-side flag reports full, and every word needs a read request. In fall-through mode the read-side flag reports that a valid word sits on the output, and the write-side flag reports room to write. The first word written into an empty buffer appears at the output without a request. A partial reset empties the buffer but keeps the captured mode and both offsets. Pointers cross between the clock domains as Gray code through two-stage synchronisers.

Top module: `modal_fifo`

## Requirements
- R1: While `mstRstN` is low and after it rises, the buffer is empty, `rdData` is zero, `almostEmptyN` is 0 and `almostFullN` is 1. The value of `fallThruSel` at the rising edge of `mstRstN` sets the mode: 0 selects standard mode (`rdFlagN`=0, `wrFlagN`=1) and 1 selects fall-through mode (`rdFlagN`=1, `wrFlagN`=0).
- R2: A low pulse on `partRstN` empties the buffer, clears `rdData` to zero and sets the flags as in R1 for the mode already active. The mode and both offset registers keep their values, whatever `fallThruSel` is doing.
- R3: A word is stored on a `wrClk` rising edge when `wrEnN` is 0 and the buffer is not full. A write attempted while full is dropped, and that word never reaches the output.
- R4: In standard mode, `rdData` takes the oldest word on a `rdClk` rising edge only when `rdEnN` is 0 and the buffer is not empty. A read request while empty leaves `rdData` and the flags unchanged. `rdFlagN` is 0 when empty and `wrFlagN` is 0 when full.
- R5: In fall-through mode, a word written into an empty buffer shows on `rdData` with `rdFlagN`=0 at the third `rdClk` rising edge after its write edge, with `rdEnN` held high. While `rdEnN` stays high the output word does not change. Each later word is presented only after a read with `rdEnN`=0. `wrFlagN` is 0 whenever a write would be accepted.
- R6: Words leave in the order in which they were accepted, in both modes.
- R7: In standard mode, `rdFlagN` rises at the second `rdClk` rising edge after the first write into an empty buffer. After a read from a full buffer, the full indication clears at the second `wrClk` rising edge after the read edge.
- R8: `almostEmptyN` is 0 while the number of held words is at or below the empty offset. The held words are those in storage plus, in fall-through mode, the one presented on the output.
- R9: `almostFullN` is 0 while the number of free storage locations is at or below the full offset.
- R10: When `cfgWe` is 1 on a `wrClk` rising edge, `cfgData` is written to the empty offset if `cfgSel` is 0, or to the full offset if `cfgSel` is 1. Master reset restores both offsets to their defaults (`AE_DEF`, `AF_DEF`, both 2).
- R11: The storage holds `DEPTH` (16) words. In fall-through mode the output register holds one more, so up to 17 words can be accepted before the first read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| mstRstN | input | 1 | Asynchronous master reset, active low; captures the mode on release |
| partRstN | input | 1 | Asynchronous partial reset, active low; keeps mode and offsets |
| fallThruSel | input | 1 | Mode choice sampled at master reset release (1 = fall-through) |
| wrEnN | input | 1 | Write enable, active low |
| wrData | input | DW | Word to write |
| rdEnN | input | 1 | Read enable, active low |
| rdData | output | DW | Registered output word |
| rdFlagN | output | 1 | Standard: empty (0 = empty); fall-through: output ready (0 = valid word) |
| wrFlagN | output | 1 | Standard: full (0 = full); fall-through: input ready (0 = room) |
| almostEmptyN | output | 1 | Programmable almost-empty, active low |
| almostFullN | output | 1 | Programmable almost-full, active low |
| cfgWe | input | 1 | Offset register write strobe (write clock) |
| cfgSel | input | 1 | Offset select: 0 empty offset, 1 full offset |
| cfgData | input | log2(DEPTH) | Offset value to write |

## Verification
The bench targets the flag timing across the clock boundary. It counts read edges from a write to the first fall-through word and to the fall of the empty flag, and counts write edges from a read to the release of full. A design with one synchroniser stage too many or too few would move those edges and fail these counts. Bursts longer than the capacity show whether a full buffer drops the extra word or overwrites unread data. They also show whether fall-through mode counts its output register as an extra slot. A partial reset is issued while the mode input carries the other value, and the offsets are then probed again at their thresholds. A design that recaptured the mode or cleared the offsets on partial reset would show the wrong flag behaviour afterwards.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } fifoMode_t;

  // strobes from control to datapath, one per clock domain
  typedef struct packed {
    logic push;   // write clock: store wrData at wrAddr
    logic load;   // read clock: move word at rdAddr into output register
  } fifoStb_t;
endpackage

// File: rtl/gray_ptr_sync.sv
module gray_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mstRstN,
  input  logic          ptrRstN,
  input  logic          fallThruSel,
  input  logic          wrEnN,
  input  logic          rdEnN,
  input  logic          cfgWe,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgData,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          rdFlagN,
  output logic          wrFlagN,
  output logic          almostEmptyN,
  output logic          almostFullN
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  function automatic logic [PW-1:0] bin2gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] gray2bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  fifoMode_t     modeW;
  logic [AW-1:0] aeOff, afOff;
  logic [PW-1:0] wrBin, wrGray, rdGraySyncW, rdBinW, wrUsed, wrFree;
  logic          fullW, pushW;

  always_ff @(posedge wrClk or negedge mstRstN) begin
    if (!mstRstN) modeW <= fifoMode_t'(fallThruSel);
    else          modeW <= modeW;
  end

  always_ff @(posedge wrClk or negedge mstRstN) begin
    if (!mstRstN) begin
      aeOff <= AW'(AE_DEF);
      afOff <= AW'(AF_DEF);
    end else if (cfgWe) begin
      if (cfgSel) afOff <= cfgData;
      else        aeOff <= cfgData;
    end
  end

  gray_ptr_sync #(.W(PW)) rdToWr (
    .clk(wrClk), .rstN(ptrRstN), .din(rdGray), .dout(rdGraySyncW)
  );

  assign rdBinW = gray2bin(rdGraySyncW);
  assign wrUsed = wrBin - rdBinW;
  assign wrFree = DEPTH_P - wrUsed;
  assign fullW  = (wrUsed == DEPTH_P);
  assign pushW  = !wrEnN && !fullW;

  always_ff @(posedge wrClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (pushW) begin
      wrBin  <= wrBin + 1'b1;
      wrGray <= bin2gray(wrBin + 1'b1);
    end
  end

  assign wrAddr      = wrBin[AW-1:0];
  assign wrFlagN     = (modeW == MODE_FWFT) ? fullW : !fullW;
  assign almostFullN = !(wrFree <= {1'b0, afOff});

  // ---------------- read domain ----------------
  fifoMode_t     modeR;
  logic [PW-1:0] rdBin, rdGray, wrGraySyncR, wrBinR, ramUsed, heldWords;
  logic          ramEmpty, outValid, loadR;

  always_ff @(posedge rdClk or negedge mstRstN) begin
    if (!mstRstN) modeR <= fifoMode_t'(fallThruSel);
    else          modeR <= modeR;
  end

  gray_ptr_sync #(.W(PW)) wrToRd (
    .clk(rdClk), .rstN(ptrRstN), .din(wrGray), .dout(wrGraySyncR)
  );

  assign wrBinR   = gray2bin(wrGraySyncR);
  assign ramUsed  = wrBinR - rdBin;
  assign ramEmpty = (ramUsed == '0);

  always_comb begin
    if (modeR == MODE_FWFT) loadR = !ramEmpty && (!outValid || !rdEnN);
    else                    loadR = !ramEmpty && !rdEnN;
  end

  always_ff @(posedge rdClk or negedge ptrRstN) begin
    if (!ptrRstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      outValid <= 1'b0;
    end else begin
      if (loadR) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= bin2gray(rdBin + 1'b1);
      end
      if (modeR == MODE_FWFT) begin
        if (loadR)       outValid <= 1'b1;
        else if (!rdEnN) outValid <= 1'b0;
      end
    end
  end

  assign rdAddr       = rdBin[AW-1:0];
  assign heldWords    = ramUsed + PW'(outValid);
  assign rdFlagN      = (modeR == MODE_FWFT) ? !outValid : !ramEmpty;
  assign almostEmptyN = !(heldWords <= {1'b0, aeOff});

  always_comb stb = '{push: pushW, load: loadR};

  // ---------------- assertions ----------------
  assert_no_overflow_R3: assert property (
    @(posedge wrClk) disable iff (!ptrRstN) wrUsed <= DEPTH_P);

  assert_no_underflow_R4: assert property (
    @(posedge rdClk) disable iff (!ptrRstN) ramUsed <= DEPTH_P);

  assert_fwft_hold_R5: assert property (
    @(posedge rdClk) disable iff (!ptrRstN)
      (modeR == MODE_FWFT && outValid && rdEnN) |=> outValid);

  assert_offset_hold_R10: assert property (
    @(posedge wrClk) disable iff (!mstRstN)
      !cfgWe |=> $stable({aeOff, afOff}));
endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import fifo_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  fifoStb_t      stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (stb.push) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)         rdData <= '0;
    else if (stb.load) rdData <= mem[rdAddr];
  end

  assert_out_hold_R4: assert property (
    @(posedge rdClk) disable iff (!rstN) !stb.load |=> $stable(rdData));
endmodule

// File: rtl/modal_fifo.sv
module modal_fifo
  import fifo_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 16,
  parameter int AE_DEF = 2,
  parameter int AF_DEF = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mstRstN,
  input  logic          partRstN,
  input  logic          fallThruSel,
  input  logic          wrEnN,
  input  logic [DW-1:0] wrData,
  input  logic          rdEnN,
  output logic [DW-1:0] rdData,
  output logic          rdFlagN,
  output logic          wrFlagN,
  output logic          almostEmptyN,
  output logic          almostFullN,
  input  logic          cfgWe,
  input  logic          cfgSel,
  input  logic [AW-1:0] cfgData
);
  logic          ptrRstN;
  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  assign ptrRstN = mstRstN & partRstN;

  fifo_ctrl #(.DEPTH(DEPTH), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .ptrRstN(ptrRstN),
    .fallThruSel(fallThruSel), .wrEnN(wrEnN), .rdEnN(rdEnN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdFlagN(rdFlagN), .wrFlagN(wrFlagN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN)
  );

  fifo_datapath #(.DW(DW), .DEPTH(DEPTH)) dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(ptrRstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/modal_fifo_test.sv
`timescale 1ns/100ps
module modal_fifo_test;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int NVEC = 6;
  // {mode, words attempted, words expected accepted}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 8'd5,  8'd5},
    {1'b1, 8'd5,  8'd5},
    {1'b0, 8'd18, 8'd16},
    {1'b1, 8'd19, 8'd17},
    {1'b0, 8'd1,  8'd1},
    {1'b1, 8'd16, 8'd16}
  };

  logic wrClk = 0, rdClk = 0;
  logic mstRstN = 0, partRstN = 1, fallThruSel = 0;
  logic wrEnN = 1, rdEnN = 1, cfgWe = 0, cfgSel = 0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] cfgData = '0;
  logic [DW-1:0] rdData;
  logic rdFlagN, wrFlagN, almostEmptyN, almostFullN;

  int checks = 0, errors = 0;
  bit curMode = 0;
  bit finished = 0;
  logic [DW-1:0] q[$];

  modal_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .rdClk(rdClk), .mstRstN(mstRstN), .partRstN(partRstN),
    .fallThruSel(fallThruSel), .wrEnN(wrEnN), .wrData(wrData),
    .rdEnN(rdEnN), .rdData(rdData), .rdFlagN(rdFlagN), .wrFlagN(wrFlagN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgData(cfgData)
  );

  always #2 wrClk = ~wrClk;                 // 250 MHz
  initial begin #1.3; forever #3.6 rdClk = ~rdClk; end  // unrelated read clock

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit isFull();
    return curMode ? wrFlagN : !wrFlagN;
  endfunction

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (4) @(negedge wrClk);
    @(negedge rdClk);
  endtask

  task automatic masterReset(input bit mode);
    @(negedge wrClk);
    fallThruSel = mode;
    mstRstN = 0;
    repeat (3) @(negedge wrClk);
    mstRstN = 1;
    curMode = mode;
    q.delete();
    @(negedge wrClk);
    fallThruSel = !mode;  // must be ignored from now on
    repeat (3) @(negedge rdClk);
  endtask

  task automatic writeBurst(input int n, input logic [DW-1:0] base, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      if (!isFull()) begin
        q.push_back(base + DW'(i));
        acc++;
      end
      wrEnN = 0;
      wrData = base + DW'(i);
    end
    @(negedge wrClk);
    wrEnN = 1;
  endtask

  task automatic cfgWrite(input bit sel, input logic [AW-1:0] val);
    @(negedge wrClk);
    cfgWe = 1; cfgSel = sel; cfgData = val;
    @(negedge wrClk);
    cfgWe = 0;
  endtask

  task automatic drain();
    bit pending = 0;
    forever begin
      @(negedge rdClk);
      rdEnN = 1;
      if (curMode) begin
        if (rdFlagN) break;
        if (q.size() == 0) chk("R6 extra word", 1, 0);
        else chk("R6 fall-through order", rdData, q.pop_front());
        rdEnN = 0;
      end else begin
        if (pending) begin
          if (q.size() == 0) chk("R6 extra word", 1, 0);
          else chk("R4 R6 standard read order", rdData, q.pop_front());
        end
        if (!rdFlagN) break;
        rdEnN = 0;
        pending = 1;
      end
    end
    chk("R6 all accepted words delivered", q.size(), 0);
  endtask

  initial begin
    int acc;
    logic [DW-1:0] held;
    #5;

    // ---- vector table: bursts in both modes ----
    for (int v = 0; v < NVEC; v++) begin
      masterReset(VEC[v][16]);
      chk("R1 rdFlagN after master reset", rdFlagN, VEC[v][16] ? 1 : 0);
      chk("R1 wrFlagN after master reset", wrFlagN, VEC[v][16] ? 0 : 1);
      chk("R1 almostEmptyN asserted", almostEmptyN, 0);
      chk("R1 almostFullN deasserted", almostFullN, 1);
      chk("R1 output cleared", rdData, 0);
      writeBurst(VEC[v][15:8], DW'(8'h10 * (v + 1)), acc);
      chk("R3 R11 accepted word count", acc, VEC[v][7:0]);
      settle();
      drain();
    end

    // ---- R4: read while empty is ignored ----
    masterReset(0);
    writeBurst(1, 8'hA5, acc);
    settle();
    drain();
    held = rdData;
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); rdEnN = 1;
    chk("R4 empty read leaves output", rdData, held);
    chk("R4 empty read leaves empty flag", rdFlagN, 0);

    // ---- R7: empty flag in standard mode clears on 2nd read edge ----
    settle();
    @(negedge wrClk); wrEnN = 0; wrData = 8'h3C; q.push_back(8'h3C);
    @(posedge wrClk);
    fork begin @(negedge wrClk); wrEnN = 1; end join_none
    @(posedge rdClk); @(negedge rdClk);
    chk("R7 still empty after one read edge", rdFlagN, 0);
    @(posedge rdClk); @(negedge rdClk);
    chk("R7 not empty after two read edges", rdFlagN, 1);
    chk("R4 no delivery without read", rdData, held);
    drain();

    // ---- R7: full release two write edges after a read ----
    writeBurst(DEPTH + 2, 8'h40, acc);
    settle();
    chk("R4 full flag low when full", wrFlagN, 0);
    @(negedge rdClk); rdEnN = 0;
    @(posedge rdClk);
    fork begin @(negedge rdClk); rdEnN = 1; end join_none
    @(posedge wrClk); @(negedge wrClk);
    chk("R7 full kept after one write edge", wrFlagN, 0);
    @(posedge wrClk); @(negedge wrClk);
    chk("R7 full released after two write edges", wrFlagN, 1);
    chk("R6 first word of full buffer", rdData, q.pop_front());
    drain();

    // ---- R5: fall-through first-word latency and hold ----
    masterReset(1);
    settle();
    @(negedge wrClk); wrEnN = 0; wrData = 8'h77; q.push_back(8'h77);
    @(posedge wrClk);
    fork begin @(negedge wrClk); wrEnN = 1; end join_none
    @(posedge rdClk); @(posedge rdClk); @(negedge rdClk);
    chk("R5 not ready after two read edges", rdFlagN, 1);
    @(posedge rdClk); @(negedge rdClk);
    chk("R5 ready at third read edge", rdFlagN, 0);
    chk("R5 first word presented", rdData, 8'h77);
    writeBurst(1, 8'h78, acc);
    settle();
    chk("R5 output held without read", rdData, 8'h77);
    chk("R5 still ready while held", rdFlagN, 0);
    chk("R5 input ready shows room", wrFlagN, 0);
    drain();

    // ---- R8 R9 R10: thresholds and offset port ----
    masterReset(0);
    writeBurst(2, 8'h01, acc);
    settle();
    chk("R8 two words at default offset", almostEmptyN, 0);
    writeBurst(1, 8'h03, acc);
    settle();
    chk("R8 three words above default offset", almostEmptyN, 1);
    cfgWrite(0, 4'd3);
    settle();
    chk("R10 empty offset written", almostEmptyN, 0);
    writeBurst(10, 8'h04, acc);
    settle();
    chk("R9 three free above default offset", almostFullN, 1);
    writeBurst(1, 8'h0E, acc);
    settle();
    chk("R9 two free at default offset", almostFullN, 0);
    cfgWrite(1, 4'd1);
    settle();
    chk("R10 full offset written", almostFullN, 1);
    @(negedge rdClk); rdEnN = 0;
    @(negedge rdClk); rdEnN = 1;
    chk("R4 read before partial reset", rdData, 8'h01);

    // ---- R2: partial reset keeps mode and offsets ----
    @(negedge wrClk); fallThruSel = 1; partRstN = 0;
    repeat (2) @(negedge wrClk);
    chk("R2 output cleared", rdData, 0);
    partRstN = 1;
    q.delete();
    settle();
    chk("R2 standard empty flag kept", rdFlagN, 0);
    chk("R2 full flag high", wrFlagN, 1);
    chk("R2 almostEmptyN asserted", almostEmptyN, 0);
    chk("R2 almostFullN deasserted", almostFullN, 1);
    writeBurst(3, 8'h50, acc);
    settle();
    chk("R2 mode kept: not empty flag", rdFlagN, 1);
    chk("R2 mode kept: no fall-through", rdData, 0);
    chk("R2 empty offset kept", almostEmptyN, 0);
    writeBurst(11, 8'h53, acc);
    settle();
    chk("R2 full offset kept", almostFullN, 1);
    writeBurst(1, 8'h5E, acc);
    settle();
    chk("R9 one free at offset one", almostFullN, 0);

    // ---- R1 R10: master reset into fall-through restores defaults ----
    masterReset(1);
    chk("R1 fall-through rdFlagN", rdFlagN, 1);
    chk("R1 fall-through wrFlagN", wrFlagN, 0);
    chk("R1 output cleared", rdData, 0);
    writeBurst(3, 8'h60, acc);
    settle();
    chk("R8 R10 held count includes output word", almostEmptyN, 1);
    chk("R9 fall-through free space", almostFullN, 1);
    drain();

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule